// File: doc/BRIEF.md
# Dual-Range Sample Combiner

This block merges the sample words of two matched converters that digitise the same bipolar signal at the same instant. The first converter, the fine channel, sees the signal after an analog gain of 2^N. Its input range therefore spans only the low-amplitude part of the signal, but with N extra bits of resolution. The second converter, the coarse channel, sees the signal at unity gain and covers the full range. For every sample pair the combiner keeps the fine word unless the fine converter is at or near its clipping limits. In that case it substitutes the coarse word, shifted left by N places so that both channels sit on one common scale that is N bits wider than a single converter.

Each sample pair arrives on two parallel two's complement buses that share one strobe. The combined word appears in a register one clock later, together with an output strobe and a flag that tells which channel supplied the value. A saturating tally counts the samples taken from the coarse channel, so the over-range fraction of a capture can be read after it. A synchronous clear input resets the tally.

Top module: `dual_range_merge`

## Requirements
- R1: While `rst_n` is low, and at the first clock after it rises with no strobe, `out_word`, `out_vld`, `out_from_b` and `b_count` are all zero.
- R2: `out_vld` is high in exactly the cycle after a clock edge that sampled `smp_vld` high, and low otherwise; back-to-back strobes give back-to-back outputs.
- R3: When the fine word is in range, `out_word` equals `fine_in` sign-extended to W+N bits.
- R4: The fine word is out of range when, read as a signed value, it is at least 2^(W-1)-1-MARGIN or at most -2^(W-1)+MARGIN (for W=8 and MARGIN=2: >=125 or <=-126).
- R5: When the fine word is out of range, `out_word` equals `coarse_in` as a signed value multiplied by 2^N, in W+N bits, with the low N bits zero.
- R6: `out_from_b` is registered with the data: 1 when the coarse word was used, 0 when the fine word was used.
- R7: `b_count` increments by one for each strobed sample that used the coarse word and holds at its all-ones value instead of wrapping.
- R8: `cnt_clr` high at a clock edge sets `b_count` to zero at that edge, even if a coarse sample is strobed in the same cycle.
- R9: With `smp_vld` low, changes on `fine_in` and `coarse_in` have no effect: `out_word`, `out_from_b` and `b_count` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_vld | input | 1 | Strobe: the sample pair on the buses is valid |
| fine_in | input | W | Fine (gained) channel sample, two's complement |
| coarse_in | input | W | Coarse (unity gain) channel sample, two's complement |
| cnt_clr | input | 1 | Synchronous clear of the coarse-sample tally |
| out_vld | output | 1 | Combined word valid, one cycle per input strobe |
| out_word | output | W+N | Combined sample on the common scale |
| out_from_b | output | 1 | 1 when the coarse channel supplied `out_word` |
| b_count | output | CNT_W | Saturating count of coarse-channel samples |

## Verification
The hardest condition to reach from the ports is a saturated tally that is cleared in the same cycle as a new coarse sample is strobed. The collision between increment, saturation hold and clear happens only after many over-range samples. The bench builds the block with a 4-bit tally so that a short run of clipped fine words fills it. It then raises the clear together with another clipped strobe. The table of vectors sits on both sides of each range threshold, positive and negative. It also pairs in-range fine words with extreme coarse words, so that a wrong selection would show up in the output value.

// File: rtl/dual_range_pkg.sv
// Package: shared types for the dual-range sample combiner.
// Assumes: nothing beyond IEEE 1800-2017.
package dual_range_pkg;

    // Which converter supplied a combined word.
    typedef enum logic {
        SRC_FINE   = 1'b0,
        SRC_COARSE = 1'b1
    } src_e;

endpackage

// File: rtl/dual_range_overrange.sv
// Module: dual_range_overrange
// Flags a fine-channel code that has reached, or come within MARGIN codes
// of, either end of the two's complement range.
// Assumes: W between 2 and 31, and MARGIN smaller than 2^(W-2).
module dual_range_overrange #(
    parameter int W      = 8,
    parameter int MARGIN = 2
) (
    input  logic [W-1:0] code,
    output logic         over
);
    localparam int HI_LIM = (1 << (W - 1)) - 1 - MARGIN;
    localparam int LO_LIM = -(1 << (W - 1)) + MARGIN;

    int code_val;

    // Compare the signed code against both limits.
    always_comb begin
        code_val = int'($signed(code));
        over     = (code_val >= HI_LIM) || (code_val <= LO_LIM);
    end
endmodule

// File: rtl/dual_range_align.sv
// Module: dual_range_align
// Puts the chosen channel onto the common W+N bit scale: the fine word is
// sign-extended and the coarse word is shifted left by N with zero fill.
// Assumes: N >= 1.
module dual_range_align #(
    parameter int W = 8,
    parameter int N = 1
) (
    input  logic [W-1:0]   fine,
    input  logic [W-1:0]   coarse,
    input  logic           use_coarse,
    output logic [W+N-1:0] word
);
    localparam int OW = W + N;

    logic [OW-1:0] fine_ext;
    logic [OW-1:0] coarse_up;

    // Widen both candidates, then pick one.
    always_comb begin
        fine_ext  = {{N{fine[W-1]}}, fine};
        coarse_up = {coarse, {N{1'b0}}};
        word      = use_coarse ? coarse_up : fine_ext;
    end
endmodule

// File: rtl/dual_range_tally.sv
// Module: dual_range_tally
// Saturating event counter with a synchronous clear that overrides counting.
// Assumes: CNT_W >= 1.
module dual_range_tally #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    // Count events, stop at all-ones, clear on request or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (inc && (count != TOP)) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/dual_range_merge.sv
// Module: dual_range_merge (top)
// Picks, for each strobed sample pair, the fine channel unless it is over
// range, and otherwise the coarse channel scaled by 2^N. The result, its
// source flag and its strobe are registered. Coarse selections are tallied.
// Assumes: both converters sample together and deliver two's complement codes.
module dual_range_merge
    import dual_range_pkg::*;
#(
    parameter int W      = 8,
    parameter int N      = 1,
    parameter int MARGIN = 2,
    parameter int CNT_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_vld,
    input  logic [W-1:0]     fine_in,
    input  logic [W-1:0]     coarse_in,
    input  logic             cnt_clr,
    output logic             out_vld,
    output logic [W+N-1:0]   out_word,
    output logic             out_from_b,
    output logic [CNT_W-1:0] b_count
);
    localparam int OW = W + N;

    logic          fine_over;
    src_e          src_sel;
    logic [OW-1:0] merged;

    dual_range_overrange #(.W(W), .MARGIN(MARGIN)) u_over (
        .code (fine_in),
        .over (fine_over)
    );

    // Map the overflow flag onto the source type.
    always_comb begin
        src_sel = fine_over ? SRC_COARSE : SRC_FINE;
    end

    dual_range_align #(.W(W), .N(N)) u_align (
        .fine       (fine_in),
        .coarse     (coarse_in),
        .use_coarse (src_sel == SRC_COARSE),
        .word       (merged)
    );

    // Output register: capture data and flag on a strobe, pulse the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld    <= 1'b0;
            out_word   <= '0;
            out_from_b <= 1'b0;
        end else begin
            out_vld <= smp_vld;
            if (smp_vld) begin
                out_word   <= merged;
                out_from_b <= (src_sel == SRC_COARSE);
            end
        end
    end

    dual_range_tally #(.CNT_W(CNT_W)) u_tally (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (smp_vld && (src_sel == SRC_COARSE)),
        .count (b_count)
    );
endmodule

// File: rtl/dual_range_merge_chk.sv
// Module: dual_range_merge_chk
// Property checker for dual_range_merge, attached by bind below.
// Assumes: the same parameters as the bound instance.
module dual_range_merge_chk #(
    parameter int W      = 8,
    parameter int N      = 1,
    parameter int MARGIN = 2,
    parameter int CNT_W  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_vld,
    input logic [W-1:0]     fine_in,
    input logic [W-1:0]     coarse_in,
    input logic             cnt_clr,
    input logic             out_vld,
    input logic [W+N-1:0]   out_word,
    input logic             out_from_b,
    input logic [CNT_W-1:0] b_count
);
    localparam int HI = (1 << (W - 1)) - 1 - MARGIN;
    localparam int LO = -(1 << (W - 1)) + MARGIN;

    logic          exp_over;
    logic [W+N-1:0] exp_fine;
    int            fv;

    // Reference range test and fine-word widening, from the requirements.
    always_comb begin
        fv       = int'($signed(fine_in));
        exp_over = (fv > HI - 1) || (fv < LO + 1);
        exp_fine = W'(fine_in) | {{N{fine_in[W-1]}}, {W{1'b0}}};
    end

    assert_vld_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_vld == $past(smp_vld)));

    assert_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(smp_vld)) |-> (out_from_b == $past(exp_over)));

    assert_fine_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(smp_vld) && !$past(exp_over)) |-> (out_word == $past(exp_fine)));

    assert_low_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_from_b |-> (out_word[N-1:0] == '0));

    assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cnt_clr)) |-> (b_count >= $past(b_count)));

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cnt_clr)) |-> (b_count == '0));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(smp_vld) && !$past(cnt_clr))
        |-> ($stable(out_word) && $stable(out_from_b) && $stable(b_count)));
endmodule

bind dual_range_merge dual_range_merge_chk #(
    .W(W), .N(N), .MARGIN(MARGIN), .CNT_W(CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_vld    (smp_vld),
    .fine_in    (fine_in),
    .coarse_in  (coarse_in),
    .cnt_clr    (cnt_clr),
    .out_vld    (out_vld),
    .out_word   (out_word),
    .out_from_b (out_from_b),
    .b_count    (b_count)
);

// File: tb/sim_dual_range_merge.sv
`timescale 1ns/1ps
// Bench for dual_range_merge: table walk, then directed reset and tally tests.
module sim_dual_range_merge;
    localparam int W = 8;
    localparam int N = 1;
    localparam int MARGIN = 2;
    localparam int CNT_W = 4;
    localparam int NV = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             smp_vld = 1'b0;
    logic [W-1:0]     fine_in = '0;
    logic [W-1:0]     coarse_in = '0;
    logic             cnt_clr = 1'b0;
    logic             out_vld;
    logic [W+N-1:0]   out_word;
    logic             out_from_b;
    logic [CNT_W-1:0] b_count;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // {fine, coarse, expected word, expected source}
    localparam logic [25:0] VEC [NV] = '{
        {8'h00, 8'h00, 9'h000, 1'b0},
        {8'h10, 8'h08, 9'h010, 1'b0},
        {8'hF0, 8'h08, 9'h1F0, 1'b0},
        {8'h7C, 8'h3E, 9'h07C, 1'b0},
        {8'h7D, 8'h3F, 9'h07E, 1'b1},
        {8'h7F, 8'h40, 9'h080, 1'b1},
        {8'h83, 8'hC1, 9'h183, 1'b0},
        {8'h82, 8'hC1, 9'h182, 1'b1},
        {8'h80, 8'h80, 9'h100, 1'b1},
        {8'h7F, 8'h7F, 9'h0FE, 1'b1},
        {8'h01, 8'h7F, 9'h001, 1'b0},
        {8'hFF, 8'h80, 9'h1FF, 1'b0}
    };

    dual_range_merge #(.W(W), .N(N), .MARGIN(MARGIN), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .fine_in(fine_in),
        .coarse_in(coarse_in), .cnt_clr(cnt_clr), .out_vld(out_vld),
        .out_word(out_word), .out_from_b(out_from_b), .b_count(b_count)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 word", int'(out_word), 0);
        chk("R1 vld", int'(out_vld), 0);
        chk("R1 flag", int'(out_from_b), 0);
        chk("R1 count", int'(b_count), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", int'({out_vld, out_word, out_from_b, b_count}), 0);

        // Table walk: each row strobed once, checked one cycle later (R3 R4 R5 R6).
        for (int i = 0; i < NV; i++) begin
            fine_in   = VEC[i][25:18];
            coarse_in = VEC[i][17:10];
            smp_vld   = 1'b1;
            @(negedge clk);
            smp_vld = 1'b0;
            chk("R2 vld", int'(out_vld), 1);
            chk(VEC[i][0] ? "R5 word" : "R3 word", int'(out_word), int'(VEC[i][9:1]));
            chk("R6 flag", int'(out_from_b), int'(VEC[i][0]));
            @(negedge clk);
            chk("R2 pulse", int'(out_vld), 0);
        end
        chk("R7 count after table", int'(b_count), 5);

        // R9: unstrobed input changes leave outputs alone.
        fine_in = 8'h7F; coarse_in = 8'h11;
        repeat (3) @(negedge clk);
        chk("R9 word", int'(out_word), 9'h1FF);
        chk("R9 flag", int'(out_from_b), 0);
        chk("R9 count", int'(b_count), 5);

        // R7: back-to-back over-range strobes fill and saturate the tally.
        fine_in = 8'h80; coarse_in = 8'hC0;
        smp_vld = 1'b1;
        for (int k = 0; k < 14; k++) begin
            @(negedge clk);
            chk("R2 back-to-back", int'(out_vld), 1);
        end
        chk("R7 saturated", int'(b_count), 15);
        chk("R5 negative coarse", int'(out_word), 9'h180);

        // R8: clear beats a simultaneous coarse sample.
        cnt_clr = 1'b1;
        @(negedge clk);
        cnt_clr = 1'b0;
        smp_vld = 1'b0;
        chk("R8 clear with strobe", int'(b_count), 0);
        @(negedge clk);
        chk("R8 stays clear", int'(b_count), 0);

        // R1: reset mid-run clears all state.
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 re-reset", int'({out_vld, out_word, out_from_b, b_count}), 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #200000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule